// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block generates the internal address for one port of a synchronous memory. At every rising clock edge it chooses one of four actions. It can take the external address, step the current address up by one, keep the current address, or jump back to a saved base address. The result is held in a register and drives the array for the cycle that follows the edge. The three controls are active low. The address strobe loads the external address, the count enable advances the counter, and the repeat control returns to the base. None of them depends on chip enables or byte enables. The counter therefore moves even while the port is deselected.

The base address sits in its own register. That register is written only by a strobe load, so a repeat lands on the last strobed address in a single edge, with no idle cycle. A flag reports whether any strobe load has been captured since reset. The action for each edge comes from a combinational mode decoder with four modes:

- MODE_REPEAT (repeat low) has the highest priority.
- MODE_LOAD (strobe low) comes next.
- MODE_COUNT (count enable low) comes after that.
- MODE_HOLD applies when no control is low.

The base register follows a two-state machine:

- BASE_EMPTY is the state after reset.
- BASE_CAPTURED is the other state.
- The transition "capture" goes from BASE_EMPTY to BASE_CAPTURED on any strobe load.
- The transition "recapture" stays in BASE_CAPTURED on later strobe loads.
- Only reset returns the machine to BASE_EMPTY.

Top module: `burst_addr_counter`

## Requirements
- R1: With repeat high (1) and strobe low (0) at an edge, the address output equals the external address sampled at that edge, from that edge onward.
- R2: With repeat and strobe high and count enable low (0), the address output becomes its previous value plus one.
- R3: Counting from the all-ones address (18'h3FFFF at the default width) gives zero.
- R4: With all three controls high, the address output keeps its previous value, whatever the external address bus carries.
- R5: With repeat low, the address output becomes the last address captured by a strobe load, regardless of the strobe and count enable.
- R6: When repeat and strobe are both low at one edge, the address output takes the base as it was before that edge, and the external address becomes the new base for later repeats.
- R7: The base-valid output rises at the edge that follows the first strobe load and stays high until reset.
- R8: A synchronous reset (active high) clears the address output and the base-valid output to 0. A repeat before any strobe load gives address 0.
- R9: When the strobe and count enable are both low with repeat high, the external address is loaded and is not incremented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W (18) | External address bus |
| ads_n | input | 1 | Address strobe, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| rpt_n | input | 1 | Repeat to base, active low |
| addr_out | output | ADDR_W (18) | Internal address for the current cycle |
| base_valid | output | 1 | High once a base address has been captured |

## Verification
The hardest case to reach is a single edge where repeat and strobe are both low. The address must take the old base while the base register takes the new external address. The effect only shows at the ports on a later repeat. The stimulus therefore first strobes one address and counts away from it. It then asserts repeat and strobe together with a different external address, and follows with a lone repeat that exposes the updated base. Wrap is reached by strobing the all-ones address, and by returning to it through repeat, before counting.

// File: rtl/bac_pkg.sv
package bac_pkg;

    // Action chosen for one clock edge, in priority order (highest last)
    typedef enum logic [1:0] {
        MODE_HOLD   = 2'd0,
        MODE_COUNT  = 2'd1,
        MODE_LOAD   = 2'd2,
        MODE_REPEAT = 2'd3
    } cnt_mode_e;

    // Occupancy of the base (repeat target) register
    typedef enum logic {
        BASE_EMPTY    = 1'b0,
        BASE_CAPTURED = 1'b1
    } base_state_e;

endpackage

// File: rtl/bac_mode_decode.sv
module bac_mode_decode
    import bac_pkg::*;
(
    input  logic      ads_n,
    input  logic      cnt_en_n,
    input  logic      rpt_n,
    output cnt_mode_e mode,
    output logic      capture
);

    // Repeat overrides strobe, strobe overrides count, count overrides hold
    always_comb begin
        if (!rpt_n) begin
            mode = MODE_REPEAT;
        end else if (!ads_n) begin
            mode = MODE_LOAD;
        end else if (!cnt_en_n) begin
            mode = MODE_COUNT;
        end else begin
            mode = MODE_HOLD;
        end
    end

    // Any strobe writes the base, even one that loses to repeat
    always_comb begin
        capture = ~ads_n;
    end

endmodule

// File: rtl/bac_base_reg.sv
module bac_base_reg
    import bac_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base_q,
    output logic              base_valid
);

    localparam logic [ADDR_W-1:0] BASE_RST = '0;

    base_state_e state_q;
    base_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BASE_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: capture (EMPTY->CAPTURED), recapture (CAPTURED->CAPTURED)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BASE_EMPTY:    if (capture) state_d = BASE_CAPTURED;
            BASE_CAPTURED: state_d = BASE_CAPTURED;
            default:       state_d = BASE_EMPTY;
        endcase
    end

    // Base value storage
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= BASE_RST;
        end else if (capture) begin
            base_q <= ext_addr;
        end
    end

    // Outputs derived from state
    always_comb begin
        unique case (state_q)
            BASE_EMPTY:    base_valid = 1'b0;
            BASE_CAPTURED: base_valid = 1'b1;
            default:       base_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/bac_addr_reg.sv
module bac_addr_reg
    import bac_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_mode_e         mode,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] addr_q
);

    localparam logic [ADDR_W-1:0] ADDR_RST = '0;
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] addr_d;
    logic [ADDR_W-1:0] addr_inc;

    // Modulo-2^ADDR_W increment: all-ones rolls to zero
    always_comb begin
        addr_inc = addr_q + ADDR_ONE;
    end

    always_comb begin
        addr_d = addr_q;
        unique case (mode)
            MODE_REPEAT: addr_d = base_q;
            MODE_LOAD:   addr_d = ext_addr;
            MODE_COUNT:  addr_d = addr_inc;
            MODE_HOLD:   addr_d = addr_q;
            default:     addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= ADDR_RST;
        end else begin
            addr_q <= addr_d;
        end
    end

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
    import bac_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ads_n,
    input  logic              cnt_en_n,
    input  logic              rpt_n,
    output logic [ADDR_W-1:0] addr_out,
    output logic              base_valid
);

    cnt_mode_e         mode;
    logic              capture;
    logic [ADDR_W-1:0] base_q;

    bac_mode_decode u_decode (
        .ads_n    (ads_n),
        .cnt_en_n (cnt_en_n),
        .rpt_n    (rpt_n),
        .mode     (mode),
        .capture  (capture)
    );

    bac_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .ext_addr   (ext_addr),
        .base_q     (base_q),
        .base_valid (base_valid)
    );

    bac_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .ext_addr (ext_addr),
        .base_q   (base_q),
        .addr_q   (addr_out)
    );

endmodule

// File: rtl/burst_addr_counter_chk.sv
module burst_addr_counter_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ads_n,
    input logic              cnt_en_n,
    input logic              rpt_n,
    input logic [ADDR_W-1:0] addr_out,
    input logic              base_valid
);

    // Independent record of the last strobed address, kept from port activity
    logic [ADDR_W-1:0] shadow_base;
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_base <= '0;
        end else if (!ads_n) begin
            shadow_base <= ext_addr;
        end
    end

    assert_load_R1: assert property (@(posedge clk) disable iff (rst)
        (rpt_n && !ads_n) |=> (addr_out == $past(ext_addr)));

    // Covers R3 as well: the truncated sum wraps all-ones to zero
    assert_count_R2: assert property (@(posedge clk) disable iff (rst)
        (rpt_n && ads_n && !cnt_en_n) |=> (addr_out == ADDR_W'($past(addr_out) + 1'b1)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (rpt_n && ads_n && cnt_en_n) |=> $stable(addr_out));

    // Covers R6: the target is the base from before a simultaneous strobe
    assert_repeat_R5: assert property (@(posedge clk) disable iff (rst)
        (!rpt_n) |=> (addr_out == $past(shadow_base)));

    assert_valid_set_R7: assert property (@(posedge clk) disable iff (rst)
        (!ads_n || base_valid) |=> base_valid);

    assert_reset_R8: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && !base_valid));

endmodule

bind burst_addr_counter burst_addr_counter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_addr_counter_test.sv
`timescale 1ns/1ps
module burst_addr_counter_test;

    localparam int W = 18;

    typedef struct packed {
        logic         ads_n;
        logic         cen_n;
        logic         rpt_n;
        logic [W-1:0] ext;
        logic [W-1:0] exp_addr;
        logic         exp_v;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 18'h00055, 18'h00000, 1'b0, 4'd8}, // repeat before strobe
        '{1'b1, 1'b0, 1'b1, 18'h00000, 18'h00001, 1'b0, 4'd2},
        '{1'b0, 1'b1, 1'b1, 18'h00100, 18'h00100, 1'b1, 4'd1},
        '{1'b1, 1'b0, 1'b1, 18'h0AAAA, 18'h00101, 1'b1, 4'd2},
        '{1'b1, 1'b0, 1'b1, 18'h00000, 18'h00102, 1'b1, 4'd2},
        '{1'b1, 1'b1, 1'b1, 18'h15555, 18'h00102, 1'b1, 4'd4},
        '{1'b0, 1'b0, 1'b1, 18'h02000, 18'h02000, 1'b1, 4'd9},
        '{1'b1, 1'b0, 1'b1, 18'h00000, 18'h02001, 1'b1, 4'd2},
        '{1'b1, 1'b0, 1'b0, 18'h00000, 18'h02000, 1'b1, 4'd5},
        '{1'b0, 1'b1, 1'b0, 18'h3FFFF, 18'h02000, 1'b1, 4'd6},
        '{1'b1, 1'b1, 1'b0, 18'h00000, 18'h3FFFF, 1'b1, 4'd6},
        '{1'b1, 1'b0, 1'b1, 18'h00000, 18'h00000, 1'b1, 4'd3},
        '{1'b1, 1'b1, 1'b1, 18'h00123, 18'h00000, 1'b1, 4'd4},
        '{1'b0, 1'b1, 1'b1, 18'h3FFFE, 18'h3FFFE, 1'b1, 4'd1},
        '{1'b1, 1'b0, 1'b1, 18'h00000, 18'h3FFFF, 1'b1, 4'd2},
        '{1'b1, 1'b0, 1'b1, 18'h00000, 18'h00000, 1'b1, 4'd3},
        '{1'b1, 1'b0, 1'b0, 18'h00000, 18'h3FFFE, 1'b1, 4'd5},
        '{1'b1, 1'b1, 1'b0, 18'h00007, 18'h3FFFE, 1'b1, 4'd5}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] ext_addr;
    logic         ads_n;
    logic         cnt_en_n;
    logic         rpt_n;
    logic [W-1:0] addr_out;
    logic         base_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    burst_addr_counter #(.ADDR_W(W)) uut (
        .clk        (clk),
        .rst        (rst),
        .ext_addr   (ext_addr),
        .ads_n      (ads_n),
        .cnt_en_n   (cnt_en_n),
        .rpt_n      (rpt_n),
        .addr_out   (addr_out),
        .base_valid (base_valid)
    );

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd1: tag = "R1";
            4'd2: tag = "R2";
            4'd3: tag = "R3";
            4'd4: tag = "R4";
            4'd5: tag = "R5";
            4'd6: tag = "R6";
            4'd7: tag = "R7";
            4'd8: tag = "R8";
            default: tag = "R9";
        endcase
    endfunction

    task automatic check(input string rq, input logic [W-1:0] ea, input logic ev);
        checks++;
        if (addr_out !== ea || base_valid !== ev) begin
            errors++;
            $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
                     rq, addr_out, base_valid, ea, ev);
        end
    endtask

    task automatic drive(input logic a, input logic c, input logic r, input logic [W-1:0] e);
        ads_n = a; cnt_en_n = c; rpt_n = r; ext_addr = e;
    endtask

    // Drive at negedge, let one rising edge pass, sample at the next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b1, 1'b1, 1'b1, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", '0, 1'b0);                 // reset state
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ads_n, VECS[i].cen_n, VECS[i].rpt_n, VECS[i].ext);
            step();
            check(tag(VECS[i].req), VECS[i].exp_addr, VECS[i].exp_v);
        end

        // R7: valid stays high through many non-strobe cycles
        drive(1'b1, 1'b0, 1'b1, '0);
        repeat (5) step();
        check("R7", 18'h00003, 1'b1);

        // R8: reset mid-run with controls active clears everything
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b1, 18'h12345);
        step();
        check("R8", '0, 1'b0);
        rst = 1'b0;
        drive(1'b1, 1'b1, 1'b0, 18'h00FFF);
        step();
        check("R8", '0, 1'b0);                 // repeat after reset lands on 0

        // R6 again: repeat+strobe, then lone repeat exposes new base
        drive(1'b0, 1'b1, 1'b1, 18'h00444);
        step();
        check("R1", 18'h00444, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 18'h00888);
        step();
        check("R6", 18'h00444, 1'b1);
        drive(1'b1, 1'b0, 1'b1, '0);
        step();
        check("R2", 18'h00445, 1'b1);
        drive(1'b1, 1'b1, 1'b0, '0);
        step();
        check("R6", 18'h00888, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule